// File: doc/BRIEF.md
# Multi-Device Serial EEPROM Bank

This block models a row of small byte-wide EEPROM devices that sit behind a serial management bus slave decoder. The decoder turns each bus transaction into one request per byte. A request carries a 7-bit device address, an operation code, a command/offset byte, a data byte and a flag that marks the first byte of a transfer. Each device owns a 256-byte array and a current-location pointer. It serves four kinds of access: a one-byte send that moves the pointer, a one-byte receive that reads sequentially from the pointer, a command write that stores a page of bytes from the command offset, and a command read that returns bytes one at a time from the command offset.

`NUM_DEV` devices answer at consecutive bus addresses starting at `BASE_ADDR`. Every device has its own array and pointer. Page writes and block reads carry no length or count byte, so every payload byte is data. Page writes that run past the top of the array continue at offset 0. Each device holds a small access state machine with three states, named IDLE, PAGE_WRITE and READ_OUT. The transitions are:
- a first payload byte, from any state, goes to PAGE_WRITE (start_page);
- a receive byte or a read data byte goes to READ_OUT (start_read);
- a stop, or a send byte, goes to IDLE (finish);
- a quick command leaves the state as it is (hold).

A read returns its byte through a registered response one clock after the request.

Top module: `smbus_eeprom_bank`

## Requirements
- R1: After reset every response output is low, every stored byte of every device reads 0 and every pointer is 0.
- R2: Device i answers only at bus address BASE_ADDR+i (0x50..0x57 by default). A request to any other address stores nothing and gives no response.
- R3: A send byte (op 1) loads the device pointer with the data byte and gives no response.
- R4: A receive byte (op 2) returns the byte at the pointer on rsp_data, with rsp_valid high, in the clock after the request. The pointer then advances by one modulo 256, so it goes from 255 to 0.
- R5: A write-data request (op 3) with first=1 stores its data byte at the command offset. Each later op 3 byte of the same page (first=0) stores at the next offset and wraps from 255 to 0. No byte is taken as a length.
- R6: A page write (op 3) does not change the current-location pointer.
- R7: A read-data request (op 4) with first=1 loads the pointer from the command offset and returns the byte there. Later op 4 bytes continue sequentially and no count byte is returned. The pointer is left one past the last byte read.
- R8: A quick command (op 0) changes neither the contents nor the pointer and gives no response.
- R9: An op 3 byte with first=0 that arrives while no page write is open is discarded. A page write is closed by a stop (op 5), by reset, or by any start of a read or a send.
- R10: The devices are independent. Writing one device never changes another device's bytes or pointer.
- R11: rsp_valid is high for exactly the clock after an accepted op 2 or op 4 request, and is low after every other operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one byte operation per clock |
| req_addr | input | 7 | Target bus address |
| req_op | input | 3 | Operation: 0 quick, 1 send, 2 receive, 3 write data, 4 read data, 5 stop |
| req_cmd | input | 8 | Command byte (start offset) |
| req_data | input | 8 | Byte written or sent |
| req_first | input | 1 | Marks the first payload byte of a transfer |
| rsp_valid | output | 1 | Read byte present |
| rsp_data | output | 8 | Read byte |

## Verification
Every result of this block appears one clock after the request that causes it. rsp_valid and rsp_data are registered at the edge that samples the request. Stored bytes and pointer moves show only in a later read. The bench therefore drives each request a quarter period after a rising edge and holds it across the next edge. It samples the response a quarter period after that edge, so each check falls inside the one cycle that belongs to its request. Effects on contents and pointer are checked through a following receive or command read.

// File: rtl/smbus_eeprom_pkg.sv
package smbus_eeprom_pkg;
    localparam int DATA_W = 8;
    localparam int BUS_ADDR_W = 7;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_QUICK = 3'd0,
        OP_SEND  = 3'd1,
        OP_RECV  = 3'd2,
        OP_WDATA = 3'd3,
        OP_RDATA = 3'd4,
        OP_STOP  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_PAGE_WRITE = 2'd1,
        ST_READ_OUT   = 2'd2
    } acc_state_e;
endpackage

// File: rtl/eeprom_addr_match.sv
module eeprom_addr_match #(
    parameter int ADDR_W = 7,
    parameter int BASE_ADDR = 'h50,
    parameter int NUM_DEV = 8
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_DEV-1:0] hit
);
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + g);
        assign hit[g] = (addr == MY_ADDR);
    end
endmodule

// File: rtl/eeprom_cell.sv
module eeprom_cell
    import smbus_eeprom_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              first,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << OFS_W;

    acc_state_e state_q, state_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [OFS_W-1:0]  ptr_q;
    logic [OFS_W-1:0]  wptr_q;
    logic [OFS_W-1:0]  cmd_ofs;
    logic [OFS_W-1:0]  data_ofs;
    logic [OFS_W-1:0]  rd_ofs;
    logic [OFS_W-1:0]  wr_ofs;
    logic              wr_en;
    logic              rd_en;
    logic              ptr_load;
    op_e               op_e_w;

    assign op_e_w   = op_e'(op);
    assign cmd_ofs  = OFS_W'(cmd);
    assign data_ofs = OFS_W'(wdata);

    // Next-state and access decode
    always_comb begin
        state_d  = state_q;
        wr_en    = 1'b0;
        rd_en    = 1'b0;
        ptr_load = 1'b0;
        wr_ofs   = wptr_q;
        rd_ofs   = ptr_q;
        if (sel) begin
            unique case (op_e_w)
                OP_QUICK: state_d = state_q;
                OP_SEND: begin
                    ptr_load = 1'b1;
                    state_d  = ST_IDLE;
                end
                OP_RECV: begin
                    rd_en   = 1'b1;
                    state_d = ST_READ_OUT;
                end
                OP_RDATA: begin
                    rd_en   = 1'b1;
                    rd_ofs  = first ? cmd_ofs : ptr_q;
                    state_d = ST_READ_OUT;
                end
                OP_WDATA: begin
                    if (first) begin
                        wr_en   = 1'b1;
                        wr_ofs  = cmd_ofs;
                        state_d = ST_PAGE_WRITE;
                    end else begin
                        unique case (state_q)
                            ST_PAGE_WRITE: wr_en = 1'b1;
                            ST_IDLE, ST_READ_OUT: wr_en = 1'b0;
                            default: wr_en = 1'b0;
                        endcase
                    end
                end
                OP_STOP: state_d = ST_IDLE;
                default: state_d = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pointers, storage and read output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            wptr_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= mem[rd_ofs];
                ptr_q   <= rd_ofs + 1'b1;
            end
            if (ptr_load) ptr_q <= data_ofs;
            if (wr_en) begin
                mem[wr_ofs] <= wdata;
                wptr_q      <= wr_ofs + 1'b1;
            end
        end
    end
endmodule

// File: rtl/eeprom_rsp_merge.sv
module eeprom_rsp_merge #(
    parameter int NUM_DEV = 8,
    parameter int DATA_W = 8
) (
    input  logic [NUM_DEV-1:0]             vld,
    input  logic [NUM_DEV-1:0][DATA_W-1:0] dat,
    output logic                           any_vld,
    output logic [DATA_W-1:0]              merged
);
    logic [NUM_DEV:0][DATA_W-1:0] acc;
    assign acc[0] = '0;
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_or
        assign acc[g+1] = acc[g] | (vld[g] ? dat[g] : '0);
    end
    assign merged  = acc[NUM_DEV];
    assign any_vld = |vld;
endmodule

// File: rtl/smbus_eeprom_bank.sv
module smbus_eeprom_bank
    import smbus_eeprom_pkg::*;
#(
    parameter int BASE_ADDR = 'h50,
    parameter int NUM_DEV = 8,
    parameter int OFS_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [BUS_ADDR_W-1:0] req_addr,
    input  logic [OP_W-1:0]       req_op,
    input  logic [DATA_W-1:0]     req_cmd,
    input  logic [DATA_W-1:0]     req_data,
    input  logic                  req_first,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_data
);
    logic [NUM_DEV-1:0]             addr_hit;
    logic [NUM_DEV-1:0]             cell_vld;
    logic [NUM_DEV-1:0][DATA_W-1:0] cell_dat;

    eeprom_addr_match #(
        .ADDR_W(BUS_ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_DEV(NUM_DEV)
    ) match_i (
        .addr(req_addr),
        .hit (addr_hit)
    );

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        eeprom_cell #(.OFS_W(OFS_W)) cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (req_valid & addr_hit[g]),
            .op      (req_op),
            .cmd     (req_cmd),
            .wdata   (req_data),
            .first   (req_first),
            .rd_valid(cell_vld[g]),
            .rd_data (cell_dat[g])
        );
    end

    eeprom_rsp_merge #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) merge_i (
        .vld    (cell_vld),
        .dat    (cell_dat),
        .any_vld(rsp_valid),
        .merged (rsp_data)
    );
endmodule

// File: rtl/smbus_eeprom_bank_chk.sv
module smbus_eeprom_bank_chk #(
    parameter int BASE_ADDR = 'h50,
    parameter int NUM_DEV = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [6:0]         req_addr,
    input logic [2:0]         req_op,
    input logic               rsp_valid,
    input logic [NUM_DEV-1:0] cell_vld
);
    logic in_range;
    logic rd_op;
    assign in_range = (int'(req_addr) >= BASE_ADDR) && (int'(req_addr) < BASE_ADDR + NUM_DEV);
    assign rd_op    = (req_op == 3'd2) || (req_op == 3'd4);

    // R11: accepted read is answered next clock
    a_r11_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_range && rd_op) |=> rsp_valid);

    // R11: no response without a preceding accepted read
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && in_range && rd_op));

    // R2: unmatched address gives no response
    a_r2_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_range) |=> !rsp_valid);

    // R2: at most one device answers
    a_r2_one_responder: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cell_vld));

    // R8: quick command gives no response
    a_r8_quick_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0) |=> !rsp_valid);
endmodule

bind smbus_eeprom_bank smbus_eeprom_bank_chk #(
    .BASE_ADDR(BASE_ADDR), .NUM_DEV(NUM_DEV)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_op   (req_op),
    .rsp_valid(rsp_valid),
    .cell_vld (cell_vld)
);

// File: tb/smbus_eeprom_bank_tb_top.sv
module smbus_eeprom_bank_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [6:0] req_addr = '0;
    logic [2:0] req_op = '0;
    logic [7:0] req_cmd = '0;
    logic [7:0] req_data = '0;
    logic       req_first = 1'b0;
    logic       rsp_valid;
    logic [7:0] rsp_data;

    int checks = 0;
    int failures = 0;
    logic       got_v;
    logic [7:0] got_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_eeprom_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_cmd(req_cmd), .req_data(req_data),
        .req_first(req_first), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drives one request across one rising edge, samples the response after it
    task automatic issue(input logic [6:0] a, input logic [2:0] op,
                         input logic [7:0] c, input logic [7:0] d, input logic f);
        req_valid = 1'b1; req_addr = a; req_op = op;
        req_cmd = c; req_data = d; req_first = f;
        @(posedge clk);
        #(CLK_PERIOD/4);
        req_valid = 1'b0;
        got_v = rsp_valid;
        got_d = rsp_data;
    endtask

    task automatic expect_read(input string req, input logic [7:0] exp);
        check(got_v === 1'b1, {req, " valid"}, int'(got_v), 1);
        check(got_d === exp, {req, " data"}, int'(got_d), int'(exp));
    endtask

    task automatic expect_quiet(input string req);
        check(got_v === 1'b0, {req, " no response"}, int'(got_v), 0);
    endtask

    task automatic t_reset;
        expect_quiet("R1 reset");
        issue(7'h50, 3'd2, 8'h00, 8'h00, 1'b0);
        expect_read("R1 pointer 0 contents 0", 8'h00);
        issue(7'h57, 3'd4, 8'hFF, 8'h00, 1'b1);
        expect_read("R1 top byte zero", 8'h00);
        issue(7'h57, 3'd5, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_send_recv;
        issue(7'h50, 3'd3, 8'h10, 8'hAA, 1'b1); expect_quiet("R11 wdata");
        issue(7'h50, 3'd3, 8'h10, 8'hBB, 1'b0);
        issue(7'h50, 3'd3, 8'h10, 8'hCC, 1'b0);
        issue(7'h50, 3'd5, 8'h00, 8'h00, 1'b0); expect_quiet("R11 stop");
        issue(7'h50, 3'd1, 8'h00, 8'h11, 1'b0); expect_quiet("R3 send");
        issue(7'h50, 3'd2, 8'h00, 8'h00, 1'b0); expect_read("R3 R5 recv at loaded ptr", 8'hBB);
        issue(7'h50, 3'd2, 8'h00, 8'h00, 1'b0); expect_read("R4 recv increments", 8'hCC);
    endtask

    task automatic t_wrap;
        issue(7'h51, 3'd3, 8'hFE, 8'h11, 1'b1);
        issue(7'h51, 3'd3, 8'hFE, 8'h22, 1'b0);
        issue(7'h51, 3'd3, 8'hFE, 8'h33, 1'b0);
        issue(7'h51, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h51, 3'd4, 8'hFE, 8'h00, 1'b1); expect_read("R7 cmd read first", 8'h11);
        issue(7'h51, 3'd4, 8'hFE, 8'h00, 1'b0); expect_read("R7 cmd read next", 8'h22);
        issue(7'h51, 3'd4, 8'hFE, 8'h00, 1'b0); expect_read("R5 write wrapped to 0", 8'h33);
        issue(7'h51, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h51, 3'd1, 8'h00, 8'hFF, 1'b0);
        issue(7'h51, 3'd2, 8'h00, 8'h00, 1'b0); expect_read("R4 recv at 255", 8'h22);
        issue(7'h51, 3'd2, 8'h00, 8'h00, 1'b0); expect_read("R4 ptr wraps to 0", 8'h33);
    endtask

    task automatic t_ptr_kept;
        issue(7'h52, 3'd3, 8'h40, 8'h66, 1'b1);
        issue(7'h52, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h52, 3'd1, 8'h00, 8'h41, 1'b0);
        issue(7'h52, 3'd3, 8'h80, 8'h5A, 1'b1);
        issue(7'h52, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h52, 3'd2, 8'h00, 8'h00, 1'b0); expect_read("R6 ptr unchanged by write", 8'h00);
        issue(7'h52, 3'd4, 8'h80, 8'h00, 1'b1); expect_read("R6 page byte stored", 8'h5A);
        issue(7'h50, 3'd4, 8'h10, 8'h00, 1'b1); expect_read("R7 read loads ptr", 8'hAA);
        issue(7'h50, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h50, 3'd2, 8'h00, 8'h00, 1'b0); expect_read("R7 ptr one past last", 8'hBB);
    endtask

    task automatic t_quick;
        issue(7'h50, 3'd1, 8'h00, 8'h10, 1'b0);
        issue(7'h50, 3'd0, 8'h10, 8'hEE, 1'b1); expect_quiet("R8 quick");
        issue(7'h50, 3'd2, 8'h00, 8'h00, 1'b0); expect_read("R8 ptr and data kept", 8'hAA);
    endtask

    task automatic t_orphan;
        issue(7'h53, 3'd3, 8'h20, 8'h77, 1'b0);
        issue(7'h53, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h53, 3'd4, 8'h20, 8'h00, 1'b1); expect_read("R9 orphan byte dropped", 8'h00);
        issue(7'h53, 3'd4, 8'h00, 8'h00, 1'b0); expect_read("R9 no store at 0x21", 8'h00);
        issue(7'h53, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h53, 3'd3, 8'h30, 8'h91, 1'b1);
        issue(7'h53, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h53, 3'd3, 8'h30, 8'h92, 1'b0);
        issue(7'h53, 3'd4, 8'h31, 8'h00, 1'b1); expect_read("R9 closed page drops byte", 8'h00);
        issue(7'h53, 3'd5, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_addr;
        issue(7'h58, 3'd3, 8'h00, 8'h99, 1'b1); expect_quiet("R2 0x58 write");
        issue(7'h58, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h4F, 3'd4, 8'h10, 8'h00, 1'b1); expect_quiet("R2 0x4F read");
        issue(7'h58, 3'd2, 8'h00, 8'h00, 1'b0); expect_quiet("R2 0x58 recv");
        issue(7'h57, 3'd4, 8'h00, 8'h00, 1'b1); expect_read("R2 miss stored nothing", 8'h00);
        issue(7'h57, 3'd5, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_indep;
        issue(7'h54, 3'd3, 8'h30, 8'hE1, 1'b1);
        issue(7'h54, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h55, 3'd4, 8'h30, 8'h00, 1'b1); expect_read("R10 neighbour untouched", 8'h00);
        issue(7'h55, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h54, 3'd4, 8'h30, 8'h00, 1'b1); expect_read("R10 own byte", 8'hE1);
        issue(7'h54, 3'd5, 8'h00, 8'h00, 1'b0);
        issue(7'h55, 3'd2, 8'h00, 8'h00, 1'b0); expect_read("R10 neighbour ptr", 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b1;
        got_v = rsp_valid;
        got_d = rsp_data;
        t_reset();
        t_send_recv();
        t_wrap();
        t_ptr_kept();
        t_quick();
        t_orphan();
        t_addr();
        t_indep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule